// File: doc/BRIEF.md
# SPI Memory Slave Command Decoder

This block is the command front end of a serial memory slave on an SPI bus in mode 0. All logic runs on a local system clock. The bus pins (serial clock, active-low chip select, data in) pass through synchronizers, and their edges are detected in that clock domain. In every chip-select-low frame, the first eight bits are taken as the opcode, most significant bit first. Two opcodes are decoded. 0x05 streams out a status byte. 0x06 requests that the write enable latch be set.

The set request is held back until chip select rises. It is committed only if the frame carried exactly eight clocks. A frame that is cut short does nothing. A frame padded with further bits does nothing either, whatever the padding holds. The latch value is shown on a register port. A synchronous clear input drops the latch, which models a write-disable command or a finished write.

The decoder is a five-state machine:
- `ST_IDLE`: waits for chip select.
- `ST_OPCODE`: collects the opcode.
- `ST_ARMED`: holds a set request whose byte count is still exactly one.
- `ST_STATUS`: streams the status byte.
- `ST_DISCARD`: ignores the rest of the frame.

The transitions are:
- `ST_IDLE` to `ST_OPCODE` on a chip-select fall.
- `ST_OPCODE` to `ST_STATUS` when the eighth bit completes opcode 0x05.
- `ST_OPCODE` to `ST_ARMED` when the eighth bit completes opcode 0x06.
- `ST_OPCODE` to `ST_DISCARD` when the eighth bit completes any other opcode.
- `ST_ARMED` to `ST_DISCARD` on any further serial-clock rise.
- Any state other than `ST_IDLE` returns to `ST_IDLE` on a chip-select rise. When the state left is `ST_ARMED`, that return sets the latch.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, `wel_q` is 0 and `spi_miso` is 0.
- R2: The first eight bits sampled on rising serial-clock edges after chip select falls form the opcode, first bit as bit 7.
- R3: Opcode 0x06 in a frame of exactly eight clocks sets `wel_q` when chip select rises, visible no later than three system-clock edges after the rise at the pin.
- R4: Opcode 0x06 followed by one or more extra clocks before chip select rises leaves `wel_q` unchanged, for any padding value (0x00, 0xFF, 0x55 included).
- R5: A frame in which chip select rises before eight clocks have arrived has no effect on `wel_q`.
- R6: After opcode 0x05, `spi_miso` presents the status byte MSB first, changing on falling serial-clock edges and starting at the falling edge that follows the eighth rise. The byte repeats while chip select stays low. The status byte has the latch at bit 1 and 0 in every other bit.
- R7: `spi_miso` is 0 while chip select is high and at any time outside a status read.
- R8: `wel_clear` clears `wel_q` at the next clock edge, and takes priority over a set committed in the same cycle.
- R9: Opcodes other than 0x05 and 0x06 leave `wel_q` unchanged and keep `spi_miso` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from bus master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master, 0 when not reading status |
| wel_clear | input | 1 | Synchronous clear of the write enable latch |
| wel_q | output | 1 | Current write enable latch value |

## Verification
Each bus pin change reaches the decoder after two synchronizer edges plus one edge-detect edge. The latch therefore moves at the third system-clock edge after chip select rises, and the bench reads `wel_q` only after six cycles. Each MISO bit is registered at the third edge after a falling serial-clock edge. The bench holds each serial-clock half period for eight system cycles and samples MISO just before the next rising edge, which is where the master would take it. The clear-priority case drives `wel_clear` for exactly the edge on which the chip-select rise commits, so both events land together.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int OPCODE_W = 8;

    localparam logic [OPCODE_W-1:0] OP_STATUS_RD = 8'h05;
    localparam logic [OPCODE_W-1:0] OP_LATCH_SET = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ARMED,
        ST_STATUS,
        ST_DISCARD
    } cmd_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
            prev  <= RESET_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
    assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/spi_opcode_shift.sv
module spi_opcode_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] next_byte,
    output logic         last
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  byte_q;
    logic [CW-1:0] cnt;

    assign next_byte = {byte_q[W-2:0], din};
    assign last      = shift && (cnt == CW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            cnt    <= '0;
        end else if (clear) begin
            byte_q <= '0;
            cnt    <= '0;
        end else if (shift && (cnt < CW'(W))) begin
            byte_q <= next_byte;
            cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_status_tx.sv
module spi_status_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         active,
    input  logic         shift,
    input  logic [W-1:0] status,
    output logic         miso
);
    localparam int IW = $clog2(W);

    logic [IW-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= IW'(W - 1);
            miso <= 1'b0;
        end else if (load) begin
            idx  <= IW'(W - 1);
            miso <= 1'b0;
        end else if (!active) begin
            miso <= 1'b0;
        end else if (shift) begin
            miso <= status[idx];
            idx  <= (idx == '0) ? IW'(W - 1) : idx - 1'b1;
        end
    end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WEL_BIT     = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    input  logic wel_clear,
    output logic wel_q
);
    logic sck_lvl, sck_rise, sck_fall;
    logic cs_lvl, cs_rise, cs_fall;
    logic mosi_lvl, mosi_rise_n, mosi_fall_n;

    spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .pin(spi_sck),
        .level(sck_lvl), .rise(sck_rise), .fall(sck_fall)
    );
    spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .pin(spi_cs_n),
        .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
    );
    spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_mosi_sync (
        .clk(clk), .rst_n(rst_n), .pin(spi_mosi),
        .level(mosi_lvl), .rise(mosi_rise_n), .fall(mosi_fall_n)
    );

    cmd_state_e state, state_nx;

    logic                shift_clear, shift_en, op_last;
    logic [OPCODE_W-1:0] op_byte;
    logic                tx_load, tx_active, tx_shift;
    logic                wel_commit;
    logic [OPCODE_W-1:0] status_byte;

    spi_opcode_shift #(.W(OPCODE_W)) u_op_shift (
        .clk(clk), .rst_n(rst_n), .clear(shift_clear), .shift(shift_en),
        .din(mosi_lvl), .next_byte(op_byte), .last(op_last)
    );

    always_comb begin
        status_byte          = '0;
        status_byte[WEL_BIT] = wel_q;
    end

    spi_status_tx #(.W(OPCODE_W)) u_status_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .active(tx_active),
        .shift(tx_shift), .status(status_byte), .miso(spi_miso)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx    = state;
        shift_clear = 1'b0;
        shift_en    = 1'b0;
        tx_load     = 1'b0;
        tx_active   = 1'b0;
        tx_shift    = 1'b0;
        wel_commit  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                shift_clear = 1'b1;
                if (cs_fall) state_nx = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (cs_rise) begin
                    state_nx = ST_IDLE;
                end else begin
                    shift_en = sck_rise;
                    if (op_last) begin
                        if (op_byte == OP_STATUS_RD) begin
                            state_nx = ST_STATUS;
                            tx_load  = 1'b1;
                        end else if (op_byte == OP_LATCH_SET) begin
                            state_nx = ST_ARMED;
                        end else begin
                            state_nx = ST_DISCARD;
                        end
                    end
                end
            end
            ST_ARMED: begin
                if (cs_rise) begin
                    state_nx   = ST_IDLE;
                    wel_commit = 1'b1;
                end else if (sck_rise) begin
                    state_nx = ST_DISCARD;
                end
            end
            ST_STATUS: begin
                tx_active = 1'b1;
                tx_shift  = sck_fall && !cs_lvl;
                if (cs_rise) state_nx = ST_IDLE;
            end
            ST_DISCARD: begin
                if (cs_rise) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wel_q <= 1'b0;
        else if (wel_clear)  wel_q <= 1'b0;
        else if (wel_commit) wel_q <= 1'b1;
    end
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk
    import spi_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input cmd_state_e state,
    input logic       cs_rise,
    input logic       sck_rise,
    input logic       wel_clear,
    input logic       wel_q,
    input logic       spi_miso
);
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clear |=> !wel_q); // R8

    AST_SET_ONLY_ON_CLEAN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(state == ST_ARMED && cs_rise)); // R3

    AST_EXTRA_CLOCK_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && sck_rise && !cs_rise) |=> (state == ST_DISCARD)); // R4

    AST_DISCARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISCARD && !cs_rise) |=> (state == ST_DISCARD)); // R9

    AST_FRAME_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (state == ST_IDLE)); // R5

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STATUS) |=> !spi_miso); // R7
endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .wel_clear(wel_clear), .wel_q(wel_q),
    .spi_miso(spi_miso)
);

// File: tb/spi_cmd_slave_bench.sv
module spi_cmd_slave_bench;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;
    logic wel_clear = 1'b0;
    logic wel_q;

    int  n_total = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    bit  model_wel = 1'b0;

    always #4 clk = ~clk;

    spi_cmd_slave u_spi_cmd_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wel_clear(wel_clear),
        .wel_q(wel_q)
    );

    function automatic logic [7:0] exp_status(bit w);
        return {6'b0, w, 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends n bits (data[n-1] first); cap[i] is MISO just before rise i.
    task automatic spi_frame(input logic [63:0] data, input int n, input bit clr_end,
                             output logic [63:0] cap);
        cap = '0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < n; i++) begin
            spi_mosi = data[n-1-i];
            idle(HALF);
            cap[i] = spi_miso;
            spi_sck = 1'b1;
            idle(HALF);
            spi_sck = 1'b0;
        end
        idle(HALF);
        spi_cs_n = 1'b1;
        if (clr_end) begin
            idle(2);
            wel_clear = 1'b1;
            idle(1);
            wel_clear = 1'b0;
        end
        idle(6);
    endtask

    function automatic void model_frame(input logic [63:0] data, input int n);
        if (n == 8 && data[7:0] == 8'h06) model_wel = 1'b1;
    endfunction

    task automatic check_miso(input logic [63:0] data, input int n, input logic [63:0] cap,
                              input bit w, input string req);
        logic [7:0] op;
        bit ok;
        op = (n >= 8) ? data[n-1 -: 8] : 8'h00;
        ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (n >= 8 && op == 8'h05 && i >= 8) begin
                if (cap[i] !== exp_status(w)[7 - ((i - 8) % 8)]) ok = 1'b0;
            end else if (cap[i] !== 1'b0) begin
                ok = 1'b0;
            end
        end
        chk(ok, req, cap[31:0], 32'h0);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        wel_clear = 1'b1;
        @(negedge clk);
        wel_clear = 1'b0;
        model_wel = 1'b0;
        idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] cap;
        logic [63:0] d;
        int n;
        bit w0;
        void'($urandom(32'd1234));
        idle(5);
        chk(wel_q === 1'b0, "R1 wel after reset", wel_q, 0);
        chk(spi_miso === 1'b0, "R1 miso after reset", spi_miso, 0);
        rst_n = 1'b1;
        idle(5);

        // R2/R3: clean single-byte set
        spi_frame(64'h06, 8, 1'b0, cap);
        chk(wel_q === 1'b1, "R3 clean 0x06 sets latch", wel_q, 1);

        // R6: status read repeats while selected
        spi_frame({8'h05, 16'h0000}, 24, 1'b0, cap);
        check_miso({8'h05, 16'h0000}, 24, cap, 1'b1, "R6 status stream wel=1");
        chk(spi_miso === 1'b0, "R7 miso low after frame", spi_miso, 0);

        // R8: clear
        pulse_clear();
        chk(wel_q === 1'b0, "R8 clear drops latch", wel_q, 0);
        spi_frame({8'h05, 8'h00}, 16, 1'b0, cap);
        check_miso({8'h05, 8'h00}, 16, cap, 1'b0, "R6 status stream wel=0");

        // R4: padded set frames
        spi_frame({8'h06, 8'h00}, 16, 1'b0, cap);
        chk(wel_q === 1'b0, "R4 pad 0x00", wel_q, 0);
        spi_frame({8'h06, 24'hFFFFFF}, 32, 1'b0, cap);
        chk(wel_q === 1'b0, "R4 pad 0xFF", wel_q, 0);
        spi_frame({8'h06, 24'h555555}, 32, 1'b0, cap);
        chk(wel_q === 1'b0, "R4 pad 0x55", wel_q, 0);
        spi_frame({8'h06, 1'b0}, 9, 1'b0, cap);
        chk(wel_q === 1'b0, "R4 one extra clock", wel_q, 0);

        // R5: short frames
        spi_frame(64'h0, 5, 1'b0, cap);
        chk(wel_q === 1'b0, "R5 five-bit frame", wel_q, 0);
        spi_frame(64'h3, 7, 1'b0, cap);
        chk(wel_q === 1'b0, "R5 seven-bit frame of 0x06 prefix", wel_q, 0);

        // R9: unknown opcode
        spi_frame({8'h07, 8'hA5}, 16, 1'b0, cap);
        chk(wel_q === 1'b0, "R9 unknown opcode latch", wel_q, 0);
        check_miso({8'h07, 8'hA5}, 16, cap, 1'b0, "R9 unknown opcode miso");

        // R8: clear coincides with commit
        spi_frame(64'h06, 8, 1'b1, cap);
        chk(wel_q === 1'b0, "R8 clear beats set", wel_q, 0);

        // Random frames
        for (int k = 0; k < 120; k++) begin
            n = $urandom_range(0, 24);
            d = {$urandom(), $urandom()};
            case ($urandom_range(0, 3))
                0: if (n >= 8) d[n-1 -: 8] = 8'h05;
                1: if (n >= 8) d[n-1 -: 8] = 8'h06;
                2: begin n = 8; d = 64'h06; end
                default: ;
            endcase
            w0 = model_wel;
            spi_frame(d, n, 1'b0, cap);
            model_frame(d, n);
            chk(wel_q === model_wel, "R3/R4/R5 random latch", wel_q, model_wel);
            check_miso(d, n, cap, w0, "R6/R7 random miso");
            if ($urandom_range(0, 7) == 0) pulse_clear();
        end

        chk(spi_miso === 1'b0, "R7 miso low while deselected", spi_miso, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule